// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the device-side position pointers for two circular descriptor rings. One ring is for receive and one is for transmit, and each ring holds a fixed number of slots. Software places new work by writing a ring's tail register. A data mover asks the block which slot to service next, and it signals with a one-cycle pulse when it has finished that slot. The block then moves that ring's head forward by one slot, wrapping at the slot count. It also emits a one-cycle write-back strobe that carries the finished slot's index and its status bits.

The two rings start from opposite conventions. The receive ring comes out of reset with almost every slot handed to the device. The transmit ring comes out of reset with no slot handed over. One slot always stays unused, so that an empty ring and a full ring look different. A write of an out-of-range index to a tail register is dropped. All four pointers can be read back through a selectable read port.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset, the receive head is 0 and the receive tail is RX_COUNT-1. The transmit head and the transmit tail are both 0.
- R2: `reg_rd_data` returns a pointer, zero-extended and combinational, chosen by `reg_rd_sel`: 0 gives the receive head, 1 the receive tail, 2 the transmit head and 3 the transmit tail.
- R3: When `reg_wr_en` is high, the tail picked by `reg_wr_sel` takes `reg_wr_data` at the next edge. A `reg_wr_sel` of 0 picks the receive tail and 1 picks the transmit tail.
- R4: A tail write whose value is not less than that ring's slot count leaves every pointer unchanged.
- R5: A ring is empty exactly when its head equals its tail. `rx_empty` and `tx_empty` report this, and `rx_index` and `tx_index` show the current head, which is the slot the data mover services next.
- R6: `tx_full` is high exactly when (transmit tail + 1) modulo TX_COUNT equals the transmit head.
- R7: A done pulse on a ring that is not empty moves that ring's head to (head + 1) modulo its slot count. A done pulse on an empty ring changes nothing and produces no write-back.
- R8: A receive completion raises `rx_wb_valid` for exactly the next cycle. `rx_wb_index` carries the slot that was finished. `rx_wb_status` bit 0 (done) is set, and bit 1 (end of packet) copies `rx_eop`.
- R9: A transmit completion raises `tx_wb_valid` for the next cycle only if `tx_cmd` bit 2 (report status) is set. The command bits are bit 0 end of packet, bit 1 insert FCS and bit 2 report status. `tx_wb_index` carries the finished slot. `tx_wb_status` bit 0 (done) is set, and bit 1 copies command bit 0.
- R10: The wrap-around works for slot counts that are not a power of two. The default transmit count is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Tail register write strobe |
| reg_wr_sel | input | 1 | 0 receive tail, 1 transmit tail |
| reg_wr_data | input | REG_W | Value written to the tail |
| reg_rd_sel | input | 2 | Pointer select for read-back |
| reg_rd_data | output | REG_W | Selected pointer, zero-extended |
| rx_empty | output | 1 | Receive ring has no slot for the device |
| rx_index | output | IDX_W | Receive slot to fill next |
| rx_done | input | 1 | Receive slot finished |
| rx_eop | input | 1 | Finished frame fit one buffer |
| rx_wb_valid | output | 1 | Receive write-back strobe |
| rx_wb_index | output | IDX_W | Slot being written back |
| rx_wb_status | output | 2 | {eop, done} |
| tx_empty | output | 1 | No pending transmit slot |
| tx_full | output | 1 | Transmit ring full from software's view |
| tx_index | output | IDX_W | Transmit slot to send next |
| tx_done | input | 1 | Transmit slot finished |
| tx_cmd | input | 3 | Command flags of the finished slot |
| tx_wb_valid | output | 1 | Transmit write-back strobe |
| tx_wb_index | output | IDX_W | Slot being written back |
| tx_wb_status | output | 2 | {eop, done} |

## Verification
The bench drives done pulses into rings that are already empty. A design that ignored emptiness would run its head past the tail and emit bogus write-backs. It writes tail values at and above the slot counts, which a design missing the range check would accept and then corrupt the ring. It walks both heads across the wrap point of a non-power-of-two transmit ring, where a power-of-two mask would step onto an index that does not exist. It mixes transmit completions with and without the report-status flag, and it fills the transmit ring until the full flag rises, catching an off-by-one in the full comparison.

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr #(
  parameter int RX_COUNT = 8,
  parameter int TX_COUNT = 6,
  parameter int REG_W    = 16,
  parameter int MAXC     = (RX_COUNT > TX_COUNT) ? RX_COUNT : TX_COUNT,
  parameter int IDX_W    = $clog2(MAXC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_wr_sel,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic [1:0]       reg_rd_sel,
  output logic [REG_W-1:0] reg_rd_data,
  output logic             rx_empty,
  output logic [IDX_W-1:0] rx_index,
  input  logic             rx_done,
  input  logic             rx_eop,
  output logic             rx_wb_valid,
  output logic [IDX_W-1:0] rx_wb_index,
  output logic [1:0]       rx_wb_status,
  output logic             tx_empty,
  output logic             tx_full,
  output logic [IDX_W-1:0] tx_index,
  input  logic             tx_done,
  input  logic [2:0]       tx_cmd,
  output logic             tx_wb_valid,
  output logic [IDX_W-1:0] tx_wb_index,
  output logic [1:0]       tx_wb_status
);
  localparam logic [IDX_W-1:0] RX_LAST = IDX_W'(RX_COUNT - 1);
  localparam logic [IDX_W-1:0] TX_LAST = IDX_W'(TX_COUNT - 1);
  localparam logic [REG_W-1:0] RX_LIM  = REG_W'(RX_COUNT);
  localparam logic [REG_W-1:0] TX_LIM  = REG_W'(TX_COUNT);
  localparam int PAD = REG_W - IDX_W;

  logic [IDX_W-1:0] rx_head, rx_tail, tx_head, tx_tail;
  logic [IDX_W-1:0] rx_head_nx, tx_head_nx, tx_tail_nx;
  logic             rx_take, tx_take;
  logic             rx_wr_ok, tx_wr_ok;

  assign rx_head_nx = (rx_head == RX_LAST) ? '0 : rx_head + 1'b1;
  assign tx_head_nx = (tx_head == TX_LAST) ? '0 : tx_head + 1'b1;
  assign tx_tail_nx = (tx_tail == TX_LAST) ? '0 : tx_tail + 1'b1;

  assign rx_empty = (rx_head == rx_tail);
  assign tx_empty = (tx_head == tx_tail);
  assign tx_full  = (tx_tail_nx == tx_head);
  assign rx_index = rx_head;
  assign tx_index = tx_head;

  assign rx_take  = rx_done && !rx_empty;
  assign tx_take  = tx_done && !tx_empty;
  assign rx_wr_ok = reg_wr_en && !reg_wr_sel && (reg_wr_data < RX_LIM);
  assign tx_wr_ok = reg_wr_en &&  reg_wr_sel && (reg_wr_data < TX_LIM);

  always_comb begin
    case (reg_rd_sel)
      2'd0:    reg_rd_data = {{PAD{1'b0}}, rx_head};
      2'd1:    reg_rd_data = {{PAD{1'b0}}, rx_tail};
      2'd2:    reg_rd_data = {{PAD{1'b0}}, tx_head};
      default: reg_rd_data = {{PAD{1'b0}}, tx_tail};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_head <= '0;
      rx_tail <= RX_LAST;
      tx_head <= '0;
      tx_tail <= '0;
    end else begin
      if (rx_take)  rx_head <= rx_head_nx;
      if (tx_take)  tx_head <= tx_head_nx;
      if (rx_wr_ok) rx_tail <= reg_wr_data[IDX_W-1:0];
      if (tx_wr_ok) tx_tail <= reg_wr_data[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wb_valid  <= 1'b0;
      rx_wb_index  <= '0;
      rx_wb_status <= '0;
      tx_wb_valid  <= 1'b0;
      tx_wb_index  <= '0;
      tx_wb_status <= '0;
    end else begin
      rx_wb_valid <= rx_take;
      if (rx_take) begin
        rx_wb_index  <= rx_head;
        rx_wb_status <= {rx_eop, 1'b1};
      end
      tx_wb_valid <= tx_take && tx_cmd[2];
      if (tx_take && tx_cmd[2]) begin
        tx_wb_index  <= tx_head;
        tx_wb_status <= {tx_cmd[0], 1'b1};
      end
    end
  end
endmodule

module ring_ptr_mgr_chk #(
  parameter int RX_COUNT = 8,
  parameter int TX_COUNT = 6,
  parameter int IDX_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] rx_head,
  input logic [IDX_W-1:0] rx_tail,
  input logic [IDX_W-1:0] tx_head,
  input logic [IDX_W-1:0] tx_tail,
  input logic             rx_done,
  input logic             tx_done,
  input logic [2:0]       tx_cmd,
  input logic             rx_empty,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             rx_wb_valid,
  input logic             tx_wb_valid
);
  localparam logic [IDX_W-1:0] RL = IDX_W'(RX_COUNT - 1);
  localparam logic [IDX_W-1:0] TL = IDX_W'(TX_COUNT - 1);

  // R4
  tail_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tail <= RL) && (tx_tail <= TL));

  // R7
  rx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_empty) |=> rx_head == (($past(rx_head) == RL) ? '0 : $past(rx_head) + 1'b1));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && !tx_empty) |=> $stable(tx_head));

  // R8
  rx_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && !rx_empty) |=> !rx_wb_valid);

  // R9
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_cmd[2]) |=> !tx_wb_valid);

  // R6
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_empty);
endmodule

bind ring_ptr_mgr ring_ptr_mgr_chk #(.RX_COUNT(RX_COUNT), .TX_COUNT(TX_COUNT), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_head(rx_head), .rx_tail(rx_tail),
  .tx_head(tx_head), .tx_tail(tx_tail), .rx_done(rx_done), .tx_done(tx_done),
  .tx_cmd(tx_cmd), .rx_empty(rx_empty), .tx_empty(tx_empty), .tx_full(tx_full),
  .rx_wb_valid(rx_wb_valid), .tx_wb_valid(tx_wb_valid));

// File: tb/ring_ptr_mgr_tb_top.sv
module ring_ptr_mgr_tb_top;
  localparam int RXC = 8, TXC = 6, RW = 16, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 0, reg_wr_sel = 0;
  logic [RW-1:0] reg_wr_data = '0;
  logic [1:0] reg_rd_sel = '0;
  logic [RW-1:0] reg_rd_data;
  logic rx_empty, rx_wb_valid, tx_empty, tx_full, tx_wb_valid;
  logic [IW-1:0] rx_index, rx_wb_index, tx_index, tx_wb_index;
  logic [1:0] rx_wb_status, tx_wb_status;
  logic rx_done = 0, rx_eop = 0, tx_done = 0;
  logic [2:0] tx_cmd = '0;

  always #10 clk = ~clk;

  ring_ptr_mgr #(.RX_COUNT(RXC), .TX_COUNT(TXC), .REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .rx_empty(rx_empty), .rx_index(rx_index), .rx_done(rx_done), .rx_eop(rx_eop),
    .rx_wb_valid(rx_wb_valid), .rx_wb_index(rx_wb_index), .rx_wb_status(rx_wb_status),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_index(tx_index), .tx_done(tx_done),
    .tx_cmd(tx_cmd), .tx_wb_valid(tx_wb_valid), .tx_wb_index(tx_wb_index),
    .tx_wb_status(tx_wb_status));

  int n_cmp = 0, n_bad = 0;
  int rxh, rxt, txh, txt;
  int e_rxv, e_rxi, e_rxs, e_txv, e_txi, e_txs;
  bit live = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: plain integers, updated on each edge from the driven inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      rxh = 0; rxt = RXC - 1; txh = 0; txt = 0;
      e_rxv = 0; e_rxi = 0; e_rxs = 0; e_txv = 0; e_txi = 0; e_txs = 0;
    end else begin
      e_rxv = 0; e_txv = 0;
      if (rx_done && rxh != rxt) begin
        e_rxv = 1; e_rxi = rxh; e_rxs = 1 + 2 * int'(rx_eop);
        rxh = (rxh + 1) % RXC;
      end
      if (tx_done && txh != txt) begin
        if (tx_cmd[2]) begin e_txv = 1; e_txi = txh; e_txs = 1 + 2 * int'(tx_cmd[0]); end
        txh = (txh + 1) % TXC;
      end
      if (reg_wr_en && !reg_wr_sel && int'(reg_wr_data) < RXC) rxt = int'(reg_wr_data);
      if (reg_wr_en &&  reg_wr_sel && int'(reg_wr_data) < TXC) txt = int'(reg_wr_data);
    end
  end

  // compare on every falling edge
  always @(negedge clk) if (live) begin
    int sel_val;
    case (reg_rd_sel)
      2'd0: sel_val = rxh; 2'd1: sel_val = rxt; 2'd2: sel_val = txh; default: sel_val = txt;
    endcase
    chk("R2 rd_data", int'(reg_rd_data), sel_val);
    chk("R5 rx_empty", int'(rx_empty), int'(rxh == rxt));
    chk("R5 tx_empty", int'(tx_empty), int'(txh == txt));
    chk("R5 rx_index", int'(rx_index), rxh);
    chk("R10 tx_index", int'(tx_index), txh);
    chk("R6 tx_full", int'(tx_full), int'(((txt + 1) % TXC) == txh));
    chk("R8 rx_wb_valid", int'(rx_wb_valid), e_rxv);
    if (e_rxv) begin
      chk("R8 rx_wb_index", int'(rx_wb_index), e_rxi);
      chk("R8 rx_wb_status", int'(rx_wb_status), e_rxs);
    end
    chk("R9 tx_wb_valid", int'(tx_wb_valid), e_txv);
    if (e_txv) begin
      chk("R9 tx_wb_index", int'(tx_wb_index), e_txi);
      chk("R9 tx_wb_status", int'(tx_wb_status), e_txs);
    end
  end

  task automatic step(bit we, bit ws, int wd, bit rd, bit re, bit td, int tc);
    @(negedge clk); #1;
    reg_wr_en = we; reg_wr_sel = ws; reg_wr_data = RW'(wd);
    rx_done = rd; rx_eop = re; tx_done = td; tx_cmd = 3'(tc);
    reg_rd_sel = reg_rd_sel + 2'd1;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", wd_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state through read-back
    reg_rd_sel = 2'd1; #1; chk("R1 rx tail reset", int'(reg_rd_data), RXC - 1);
    reg_rd_sel = 2'd0; #1; chk("R1 rx head reset", int'(reg_rd_data), 0);
    reg_rd_sel = 2'd3; #1; chk("R1 tx tail reset", int'(reg_rd_data), 0);
    chk("R1 tx empty at reset", int'(tx_empty), 1);
    live = 1;
    // R7 drain receive ring, then pulse on empty
    for (int i = 0; i < RXC + 2; i++) step(0, 0, 0, 1, i[0], 0, 0);
    idle();
    // R4 out-of-range tail writes
    step(1, 0, RXC, 0, 0, 0, 0);
    step(1, 1, TXC, 0, 0, 0, 0);
    step(1, 1, 16'hFFFF, 0, 0, 0, 0);
    // R3 legal writes
    step(1, 0, 3, 0, 0, 0, 0);
    step(1, 1, TXC - 1, 0, 0, 0, 0);
    idle(); idle();
    // R9 transmit completions with mixed flags, R10 wrap at 6
    for (int i = 0; i < TXC + 1; i++) step(0, 0, 0, 0, 0, 1, i % 8);
    step(1, 1, 2, 0, 0, 1, 7);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, 1, 5);
    // random traffic
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 9),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7));
    idle(); idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule